// File: doc/BRIEF.md
# Low-Power Real-Time Counter

The block is a slow-running up-counter for always-on timekeeping. A single-cycle clock enable at 32.768 kHz drives it. A programmable divider reduces that rate before it reaches a counter of CNT_W bits (24 by default). Software controls the block through a small synchronous register bus. Each register is one word, selected by a 6-bit word address.

Software starts, stops and clears the counter by writing a 1 to task words. It programs up to four compare values and reads the current count. Six event sources each keep a sticky flag:

- tick, on every counter increment;
- overflow, when the counter wraps;
- one compare event per channel.

Each source has two separate enable masks. The interrupt mask feeds one level-sensitive interrupt line. The event mask gates one-cycle pulses towards an event-routing fabric. Each mask is changed through its own set word and its own clear word, so software never needs a read-modify-write.

Source bit positions are shared by both masks and by the event output vector:

- bit 0 is tick;
- bit 1 is overflow;
- bit 2+c is compare channel c.

Top module: `rtc_counter`

## Requirements
- R1: After reset the counter is 0 and stopped. The prescaler, compare values, both enable masks and all flags are 0, `irq` is low and `evt_out` is all zero.
- R2: While running, the counter advances by one on every (P+1)-th asserted `tick_en`, where P is the prescaler at word 0x10, bits [PRE_W-1:0]. The count reads at word 0x11. The internal divider restarts from zero on a start task and on a clear task.
- R3: Writing a word whose bit 0 is 1 triggers a task: start at 0x00, stop at 0x01, clear at 0x02. A write with bit 0 clear has no effect. While stopped the count holds. Clear sets the count to 0.
- R4: Writes to the prescaler word are ignored while the counter runs.
- R5: The tick flag (word 0x04, bit 0) sets on every increment. The overflow flag (word 0x05, bit 0) sets on the increment that takes the count from all-ones to 0.
- R6: Compare channel c holds its value at word 0x14+c. Its flag (word 0x06+c) sets on the increment at which the count becomes equal to that value, including a value of 0 reached by wrapping. A clear task never sets it.
- R7: Writing a word with bit 0 equal to 0 to a flag word clears that flag. Writing 1 leaves the flag unchanged. An event in the same cycle as a clearing write wins.
- R8: The interrupt mask is set by writing ones to word 0x0C and cleared by writing ones to word 0x0D. Zero bits leave their enables unchanged. Both words read back the mask.
- R9: `irq` is high exactly when some source has both its flag and its interrupt enable set.
- R10: The event mask uses words 0x0E (set) and 0x0F (clear) with the same rules as R8, independent of the interrupt mask. `evt_out[s]` is high for one cycle after an increment that raised source s, and only if its event enable is set.
- R11: A read request (`bus_req` high, `bus_we` low) returns its data on `bus_rdata` with `bus_rvalid` high in the following cycle. `bus_rvalid` is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32.768 kHz clock enable, one cycle wide |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | DATA_W (24) | Write data |
| bus_rdata | output | DATA_W (24) | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq | output | 1 | Combined level interrupt |
| evt_out | output | NSRC (6) | Per-source event pulses |

## Verification
The assertions take for granted that a task write never arrives in the same cycle as an increment step, except for clear, which the counter treats as overriding the step. They also assume that reset is held for several cycles so that every register has a defined past value. The stimulus drops `tick_en` for every bus write that matters to the count, with one exception: the flag-clear race of R7 is a deliberate single-cycle overlap. The bench builds the counter 10 bits wide, so the wrap and the compare-at-zero case are reached in about a thousand ticks.

// File: rtl/rtc_counter_pkg.sv
package rtc_counter_pkg;

    localparam int ADDR_W   = 6;
    localparam int SRC_TICK = 0;
    localparam int SRC_OVF  = 1;
    localparam int SRC_CMP0 = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_START     = 6'h00,
        A_STOP      = 6'h01,
        A_CLEAR     = 6'h02,
        A_FLAG_TICK = 6'h04,
        A_FLAG_OVF  = 6'h05,
        A_FLAG_CMP0 = 6'h06,
        A_IEN_SET   = 6'h0C,
        A_IEN_CLR   = 6'h0D,
        A_EEN_SET   = 6'h0E,
        A_EEN_CLR   = 6'h0F,
        A_PRESC     = 6'h10,
        A_COUNT     = 6'h11,
        A_CMP0      = 6'h14
    } reg_addr_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic clear;
    } task_req_t;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rtc_counter_regs.sv
module rtc_counter_regs
    import rtc_counter_pkg::*;
#(
    parameter int PRE_W   = 12,
    parameter int CNT_W   = 24,
    parameter int NUM_CMP = 4,
    parameter int NSRC    = 6,
    parameter int DATA_W  = 24
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            bus_req,
    input  logic                            bus_we,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    input  logic                            running,
    input  logic [CNT_W-1:0]                count,
    input  logic [NSRC-1:0]                 flags,
    output task_req_t                       tasks,
    output logic [NSRC-1:0]                 flag_clr,
    output logic [PRE_W-1:0]                presc,
    output logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val,
    output logic [NSRC-1:0]                 irq_en,
    output logic [NSRC-1:0]                 evt_en,
    output logic [DATA_W-1:0]               bus_rdata,
    output logic                            bus_rvalid
);

    logic              wr;
    logic [DATA_W-1:0] rd_mux;

    assign wr = bus_req && bus_we;

    // Task strobes and flag clears are single-cycle decodes of a write.
    always_comb begin
        tasks    = '0;
        flag_clr = '0;
        if (wr && bus_wdata[0]) begin
            tasks.start = (bus_addr == A_START);
            tasks.stop  = (bus_addr == A_STOP);
            tasks.clear = (bus_addr == A_CLEAR);
        end
        if (wr && !bus_wdata[0]) begin
            flag_clr[SRC_TICK] = (bus_addr == A_FLAG_TICK);
            flag_clr[SRC_OVF]  = (bus_addr == A_FLAG_OVF);
            for (int c = 0; c < NUM_CMP; c++)
                flag_clr[SRC_CMP0+c] = (bus_addr == ADDR_W'(A_FLAG_CMP0 + c));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            presc   <= '0;
            cmp_val <= '0;
            irq_en  <= '0;
            evt_en  <= '0;
        end else if (wr) begin
            case (bus_addr)
                A_IEN_SET: irq_en <= irq_en | bus_wdata[NSRC-1:0];
                A_IEN_CLR: irq_en <= irq_en & ~bus_wdata[NSRC-1:0];
                A_EEN_SET: evt_en <= evt_en | bus_wdata[NSRC-1:0];
                A_EEN_CLR: evt_en <= evt_en & ~bus_wdata[NSRC-1:0];
                A_PRESC:   if (!running) presc <= bus_wdata[PRE_W-1:0];
                default: ;
            endcase
            for (int c = 0; c < NUM_CMP; c++)
                if (bus_addr == ADDR_W'(A_CMP0 + c))
                    cmp_val[c] <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_FLAG_TICK:          rd_mux[0]          = flags[SRC_TICK];
            A_FLAG_OVF:           rd_mux[0]          = flags[SRC_OVF];
            A_IEN_SET, A_IEN_CLR: rd_mux[NSRC-1:0]   = irq_en;
            A_EEN_SET, A_EEN_CLR: rd_mux[NSRC-1:0]   = evt_en;
            A_PRESC:              rd_mux[PRE_W-1:0]  = presc;
            A_COUNT:              rd_mux[CNT_W-1:0]  = count;
            default: ;
        endcase
        for (int c = 0; c < NUM_CMP; c++) begin
            if (bus_addr == ADDR_W'(A_FLAG_CMP0 + c)) rd_mux[0] = flags[SRC_CMP0+c];
            if (bus_addr == ADDR_W'(A_CMP0 + c))      rd_mux[CNT_W-1:0] = cmp_val[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_req && !bus_we;
            if (bus_req && !bus_we) bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/rtc_counter_core.sv
module rtc_counter_core
    import rtc_counter_pkg::*;
#(
    parameter int PRE_W   = 12,
    parameter int CNT_W   = 24,
    parameter int NUM_CMP = 4,
    parameter int NSRC    = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            tick_en,
    input  task_req_t                       tasks,
    input  logic [PRE_W-1:0]                presc,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val,
    output logic                            running,
    output logic [CNT_W-1:0]                count,
    output logic [NSRC-1:0]                 step_evt
);

    logic [PRE_W-1:0] div_q;
    logic             div_wrap;
    logic             step;
    logic [CNT_W-1:0] count_next;

    assign div_wrap   = (div_q == presc);
    assign step       = running && tick_en && div_wrap && !(tasks.start || tasks.stop || tasks.clear);
    assign count_next = count + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)                             div_q <= '0;
        else if (tasks.start || tasks.clear) div_q <= '0;
        else if (running && tick_en)         div_q <= div_wrap ? '0 : div_q + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)              running <= 1'b0;
        else if (tasks.stop)  running <= 1'b0;
        else if (tasks.start) running <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)              count <= '0;
        else if (tasks.clear) count <= '0;
        else if (step)        count <= count_next;
    end

    assign step_evt[SRC_TICK] = step;
    assign step_evt[SRC_OVF]  = step && (count == '1);

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        assign step_evt[SRC_CMP0+c] = step && (count_next == cmp_val[c]);
    end

endmodule

// File: rtl/rtc_counter_flags.sv
module rtc_counter_flags #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] step_evt,
    input  logic [NSRC-1:0] flag_clr,
    input  logic [NSRC-1:0] irq_en,
    input  logic [NSRC-1:0] evt_en,
    output logic [NSRC-1:0] flags,
    output logic            irq,
    output logic [NSRC-1:0] evt_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            evt_out <= '0;
        end else begin
            flags   <= (flags & ~flag_clr) | step_evt;
            evt_out <= step_evt & evt_en;
        end
    end

    assign irq = |(flags & irq_en);

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_counter_pkg::*;
#(
    parameter int  PRE_W   = 12,
    parameter int  CNT_W   = 24,
    parameter int  NUM_CMP = 4,
    localparam int NSRC    = 2 + NUM_CMP,
    localparam int DATA_W  = max2(CNT_W, PRE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              irq,
    output logic [NSRC-1:0]   evt_out
);

    task_req_t                     tasks;
    logic [NSRC-1:0]               flag_clr;
    logic [PRE_W-1:0]              presc;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
    logic [NSRC-1:0]               irq_en;
    logic [NSRC-1:0]               evt_en;
    logic                          running;
    logic [CNT_W-1:0]              count;
    logic [NSRC-1:0]               step_evt;
    logic [NSRC-1:0]               flags;
    logic                          clear_req;

    assign clear_req = tasks.clear;

    rtc_counter_regs #(
        .PRE_W(PRE_W), .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .NSRC(NSRC), .DATA_W(DATA_W)
    ) regs_i (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .running(running), .count(count), .flags(flags),
        .tasks(tasks), .flag_clr(flag_clr), .presc(presc), .cmp_val(cmp_val),
        .irq_en(irq_en), .evt_en(evt_en),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    rtc_counter_core #(
        .PRE_W(PRE_W), .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .NSRC(NSRC)
    ) core_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .tasks(tasks),
        .presc(presc), .cmp_val(cmp_val),
        .running(running), .count(count), .step_evt(step_evt)
    );

    rtc_counter_flags #(
        .NSRC(NSRC)
    ) flags_i (
        .clk(clk), .rst(rst), .step_evt(step_evt), .flag_clr(flag_clr),
        .irq_en(irq_en), .evt_en(evt_en),
        .flags(flags), .irq(irq), .evt_out(evt_out)
    );

endmodule

// File: rtl/rtc_counter_chk.sv
module rtc_counter_chk #(
    parameter int PRE_W = 12,
    parameter int CNT_W = 24,
    parameter int NSRC  = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             running,
    input logic             clear_req,
    input logic [CNT_W-1:0] count,
    input logic [PRE_W-1:0] presc,
    input logic [NSRC-1:0]  flags,
    input logic [NSRC-1:0]  evt_en,
    input logic [NSRC-1:0]  evt_out,
    input logic             irq,
    input logic             bus_req,
    input logic             bus_we,
    input logic             bus_rvalid
);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !clear_req |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1))); // R2

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!running && !clear_req) |=> $stable(count)); // R3

    AST_PRESC_LOCK: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(presc)); // R4

    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> (count == '0)); // R5

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0)); // R9

    AST_EVT_GATED: assert property (@(posedge clk) disable iff (rst)
        (evt_out & ~$past(evt_en)) == '0); // R10

    AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_req && !bus_we)); // R11

endmodule

bind rtc_counter rtc_counter_chk #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .NSRC(NSRC)
) chk_i (
    .clk(clk), .rst(rst), .running(running), .clear_req(clear_req),
    .count(count), .presc(presc), .flags(flags), .evt_en(evt_en),
    .evt_out(evt_out), .irq(irq),
    .bus_req(bus_req), .bus_we(bus_we), .bus_rvalid(bus_rvalid)
);

// File: tb/rtc_counter_tb_top.sv
module rtc_counter_tb_top;
    import rtc_counter_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_W      = 12;
    localparam int CNT_W      = 10;
    localparam int NUM_CMP    = 4;
    localparam int NSRC       = 2 + NUM_CMP;
    localparam int DATA_W     = max2(CNT_W, PRE_W);
    localparam int MAXV       = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_rvalid;
    logic              irq;
    logic [NSRC-1:0]   evt_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_counter #(.PRE_W(PRE_W), .CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq(irq), .evt_out(evt_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver tasks start and end at a falling edge.
    task automatic bus_write(input logic [ADDR_W-1:0] a, input int d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = DATA_W'(d);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input int exp, input string tag);
        exp_item_t it;
        it.exp = DATA_W'(exp);
        it.tag = tag;
        sb_q.push_back(it);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // Monitor: pops an expected item whenever read data is returned.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && bus_rvalid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R11 unexpected rvalid", 1, 0);
                end else begin
                    exp_item_t it;
                    it = sb_q.pop_front();
                    check(bus_rdata == it.exp, it.tag, int'(bus_rdata), int'(it.exp));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(irq == 1'b0, "R1 irq", int'(irq), 0);
        check(evt_out == '0, "R1 evt_out", int'(evt_out), 0);
        check(bus_rvalid == 1'b0, "R11 rvalid idle", int'(bus_rvalid), 0);
        bus_read(A_COUNT, 0, "R1 count");
        bus_read(A_IEN_SET, 0, "R1 irq mask");
        bus_read(A_EEN_SET, 0, "R1 evt mask");
        bus_read(A_FLAG_TICK, 0, "R1 tick flag");
        bus_read(A_PRESC, 0, "R1 prescaler");
        bus_read(ADDR_W'(A_CMP0 + 2), 0, "R1 compare2");

        // R2 divide by three
        bus_write(A_PRESC, 2);
        bus_write(A_START, 1);
        run_ticks(9);
        bus_read(A_COUNT, 3, "R2 count after 9 ticks at P=2");
        bus_read(A_FLAG_TICK, 1, "R5 tick flag");

        // R3 stop holds
        bus_write(A_STOP, 1);
        run_ticks(6);
        bus_read(A_COUNT, 3, "R3 stopped count holds");

        // R4 prescaler locked while running; R2 divider restarts on start
        bus_write(A_START, 1);
        bus_write(A_PRESC, 0);
        run_ticks(3);
        bus_read(A_COUNT, 4, "R4 ignored prescaler write");
        bus_read(A_PRESC, 2, "R4 prescaler unchanged");

        // R2 divider restarts on clear, R3 clear
        run_ticks(1);
        bus_write(A_CLEAR, 1);
        bus_read(A_COUNT, 0, "R3 clear");
        run_ticks(2);
        bus_read(A_COUNT, 0, "R2 divider restart on clear");
        run_ticks(1);
        bus_read(A_COUNT, 1, "R2 first step after clear");

        // R3 writing zero to a task word does nothing
        bus_write(A_STOP, 0);
        run_ticks(3);
        bus_read(A_COUNT, 2, "R3 zero task write ignored");

        // R7 flag clear rules
        bus_write(A_STOP, 1);
        bus_write(A_PRESC, 0);
        bus_read(A_PRESC, 0, "R4 prescaler writable when stopped");
        bus_write(A_CLEAR, 1);
        bus_write(A_FLAG_TICK, 0);
        bus_read(A_FLAG_TICK, 0, "R7 flag cleared by zero");
        bus_write(A_FLAG_TICK, 1);
        bus_read(A_FLAG_TICK, 0, "R7 writing one leaves flag");

        // R6 compare, R9 interrupt
        bus_write(A_CMP0, 5);
        bus_write(A_IEN_SET, 6'h04);
        bus_write(A_START, 1);
        run_ticks(4);
        check(irq == 1'b0, "R9 irq before compare", int'(irq), 0);
        bus_read(A_COUNT, 4, "R2 count at P=0");
        run_ticks(1);
        check(irq == 1'b1, "R9 irq on compare0", int'(irq), 1);
        bus_read(A_FLAG_CMP0, 1, "R6 compare0 flag");
        bus_write(A_FLAG_CMP0, 0);
        check(irq == 1'b0, "R7 irq drops after flag clear", int'(irq), 0);

        // R8 set/clear mask words
        bus_write(A_IEN_SET, 6'h03);
        bus_read(A_IEN_SET, 6'h07, "R8 set merges");
        bus_write(A_IEN_CLR, 6'h01);
        bus_read(A_IEN_CLR, 6'h06, "R8 clear only ones");
        check(irq == 1'b0, "R9 tick flag masked", int'(irq), 0);
        bus_write(A_IEN_SET, 6'h01);
        check(irq == 1'b1, "R9 tick flag enabled", int'(irq), 1);
        bus_write(A_IEN_CLR, 6'h3F);
        bus_read(A_IEN_SET, 0, "R8 clear all");

        // R10 event enables
        bus_write(A_EEN_SET, 6'h01);
        bus_read(A_EEN_SET, 6'h01, "R10 evt mask set");
        bus_read(A_IEN_SET, 0, "R10 irq mask independent");
        run_ticks(1);
        check(evt_out == 6'h01, "R10 tick pulse", int'(evt_out), 1);
        check(irq == 1'b0, "R9 no irq without enable", int'(irq), 0);
        @(negedge clk);
        check(evt_out == 6'h00, "R10 pulse one cycle", int'(evt_out), 0);
        bus_write(ADDR_W'(A_CMP0 + 1), 8);
        run_ticks(2);
        check(evt_out == 6'h01, "R10 compare1 not routed", int'(evt_out), 1);
        bus_read(ADDR_W'(A_FLAG_CMP0 + 1), 1, "R6 compare1 flag");

        // R5 overflow, R6 compare at zero by wrap only
        bus_write(A_STOP, 1);
        bus_write(ADDR_W'(A_CMP0 + 3), 0);
        bus_write(A_CLEAR, 1);
        bus_read(ADDR_W'(A_FLAG_CMP0 + 3), 0, "R6 clear does not fire compare");
        bus_write(A_EEN_SET, 6'h02);
        bus_write(A_START, 1);
        run_ticks(MAXV);
        bus_read(A_COUNT, MAXV, "R2 count at all-ones");
        bus_read(A_FLAG_OVF, 0, "R5 no overflow yet");
        run_ticks(1);
        check(evt_out == 6'h03, "R10 tick and overflow pulses", int'(evt_out), 3);
        bus_read(A_COUNT, 0, "R5 wrapped count");
        bus_read(A_FLAG_OVF, 1, "R5 overflow flag");
        bus_read(ADDR_W'(A_FLAG_CMP0 + 3), 1, "R6 compare3 at zero on wrap");

        // R7 event beats clear in the same cycle
        bus_write(A_FLAG_TICK, 0);
        bus_read(A_FLAG_TICK, 0, "R7 tick flag cleared");
        tick_en = 1'b1;
        bus_write(A_FLAG_TICK, 0);
        tick_en = 1'b0;
        bus_read(A_FLAG_TICK, 1, "R7 event wins over clear");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R11 all reads answered", sb_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule